// File: doc/BRIEF.md
# DRAM Refresh and Power-State Sequencer

This block watches the row-enable command stream of a cached DRAM model and keeps its array refreshed without touching the row tags or cache rows. A row-enable cycle opened with the refresh request asserted refreshes the row held in an internal counter. A dedicated entry encoding puts the part into self-refresh, where an internal timer issues refreshes on its own. A start-up tracker raises a ready flag once the required warm-up has been seen. A deadline monitor reports any window in which too few refreshes took place. Cache reads may continue in parallel, so the block only issues a refresh strobe and a row address to the array.

All control inputs are active-high samples taken on the block clock. A row-enable cycle starts on the first clock where `row_act` is seen high after being low, and it ends on the first clock where it is seen low again. Bank membership is decided by two row-address bits, bit 9 (upper) and bit 2 (lower), which give a bank index of 0 to 3.

Top module: `rfsh_seq`

## Requirements
- R1: A cycle start with `rfsh_req` high is an internal refresh, whatever the state of `sel`. It makes `rfsh_stb` high for exactly the one cycle after the start edge, and `rfsh_row` then shows the counter value.
- R2: The refresh counter is 0 after reset. It advances by one when an internal refresh cycle ends, or right after each self-refresh strobe. It wraps modulo 2^RFSH_ROW_W, so successive strobes always carry consecutive rows.
- R3: A start with `sel` low and `rfsh_req` low is ignored unless it is the self-refresh entry encoding. It produces no strobe and does not count toward start-up.
- R4: A start with `sel` low, `wr_mode` high, `rfsh_req` low, `wr_en` low and `col_strobe` high enters self-refresh. `self_rfsh` is high from the next cycle. Every SR_PERIOD cycles the block issues one counter-addressed strobe. The mode ends on the first clock where `row_act` is low, and that clock issues no strobe.
- R5: For PRECHG_CYC clock edges after self-refresh ends, a rising `row_act` is ignored entirely, including a refresh request.
- R6: `ready` needs INIT_CYC counted starts first (internal refresh, read or write, with `sel` high for reads and writes). After that, each of the four banks needs reads to two different rows. Reads made before the INIT_CYC count is complete do not count. `ready` rises two edges after the completing read and stays high.
- R7: A repeated read to the same row of a bank does not complete that bank.
- R8: A write cycle (`sel` high, `wr_mode` high) during which `col_strobe` is never high counts as one externally addressed refresh when it ends. Read cycles never count as refreshes.
- R9: The refresh windows are WIN_CYC cycles long and are counted from reset. At the end of each window, `dl_err` takes the value "fewer than MIN_RFSH refreshes (strobes plus external) in that window". It keeps that value until the next window ends.
- R10: During and just after reset, `rfsh_stb`, `rfsh_row`, `self_rfsh`, `ready` and `dl_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| row_act | input | 1 | Row enable asserted |
| sel | input | 1 | Chip selected |
| wr_mode | input | 1 | Cycle type: 1 write, 0 read |
| rfsh_req | input | 1 | Refresh request asserted at cycle start |
| col_strobe | input | 1 | Column latch strobe asserted |
| wr_en | input | 1 | Write data enable asserted |
| row_addr | input | ROW_W | Row address sampled at cycle start |
| rfsh_stb | output | 1 | One-cycle refresh strobe to the array |
| rfsh_row | output | RFSH_ROW_W | Row to refresh, valid with the strobe |
| self_rfsh | output | 1 | Self-refresh mode active |
| ready | output | 1 | Start-up sequence complete |
| dl_err | output | 1 | Last window had too few refreshes |

## Verification
The bench goes after the moment the counter advances. A design that advanced it at the start of an internal cycle, or forgot to advance it after a self-refresh strobe, would repeat or skip a row; the same happens at the wrap from the top row back to 0. It opens a refresh request inside the post-self-refresh recovery gap: a design that did not block it would strobe early. It makes an early read before the warm-up count is complete and repeats a same-row read, so a tracker that counted early reads or accepted equal rows would raise `ready` too soon. It also mixes deselected reads, written and column-less writes, and long idle spans. A monitor that counted reads or deselected cycles as refreshes, or that never cleared its error, would show the wrong `dl_err`.

// File: rtl/rfsq_pkg.sv
package rfsq_pkg;
  typedef enum logic [2:0] {
    CK_NONE = 3'd0,
    CK_INT  = 3'd1,
    CK_SELF = 3'd2,
    CK_RD   = 3'd3,
    CK_WR   = 3'd4
  } cyc_kind_t;

  typedef enum logic [1:0] {
    RM_IDLE  = 2'd0,
    RM_INT   = 2'd1,
    RM_SELF  = 2'd2,
    RM_RECOV = 2'd3
  } rmode_t;

  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,
    BK_ONE   = 2'd1,
    BK_DONE  = 2'd2
  } bank_st_t;
endpackage

// File: rtl/rfsq_cycdec.sv
module rfsq_cycdec
  import rfsq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      row_act,
  input  logic      sel,
  input  logic      wr_mode,
  input  logic      rfsh_req,
  input  logic      col_strobe,
  input  logic      wr_en,
  input  logic      blk,
  output cyc_kind_t start_kind,
  output logic      stop,
  output logic      ext_rfsh
);
  logic      ra_q;
  logic      start;
  cyc_kind_t cur_q;
  logic      col_seen_q;

  assign start = row_act & ~ra_q;
  assign stop  = ~row_act & ra_q;

  // classify the cycle opened at this edge
  always_comb begin
    if (!start || blk)                                        start_kind = CK_NONE;
    else if (rfsh_req)                                        start_kind = CK_INT;
    else if (!sel && wr_mode && !wr_en && col_strobe)         start_kind = CK_SELF;
    else if (!sel)                                            start_kind = CK_NONE;
    else if (wr_mode)                                         start_kind = CK_WR;
    else                                                      start_kind = CK_RD;
  end

  // a write cycle that never strobed a column is an addressed refresh
  assign ext_rfsh = stop && (cur_q == CK_WR) && !col_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q       <= 1'b0;
      cur_q      <= CK_NONE;
      col_seen_q <= 1'b0;
    end else begin
      ra_q <= row_act;
      if (start) begin
        cur_q      <= start_kind;
        col_seen_q <= col_strobe;
      end else begin
        col_seen_q <= col_seen_q | col_strobe;
      end
    end
  end
endmodule

// File: rtl/rfsq_rowctr.sv
module rfsq_rowctr
  import rfsq_pkg::*;
#(
  parameter int RFSH_ROW_W = 10,
  parameter int SR_PERIOD  = 16,
  parameter int PRECHG_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cyc_kind_t             start_kind,
  input  logic                  stop,
  output logic                  rfsh_stb,
  output logic [RFSH_ROW_W-1:0] rfsh_row,
  output logic                  self_rfsh,
  output logic                  blk
);
  localparam int TMR_W = (SR_PERIOD > 1) ? $clog2(SR_PERIOD) : 1;
  localparam int REC_W = $clog2(PRECHG_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SR_PERIOD - 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(PRECHG_CYC - 1);

  rmode_t                mode_q;
  logic [RFSH_ROW_W-1:0] cnt_q;
  logic [TMR_W-1:0]      tmr_q;
  logic [REC_W-1:0]      rec_q;

  assign self_rfsh = (mode_q == RM_SELF);
  assign blk       = (mode_q == RM_RECOV);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= RM_IDLE;
      cnt_q    <= '0;
      tmr_q    <= '0;
      rec_q    <= '0;
      rfsh_stb <= 1'b0;
      rfsh_row <= '0;
    end else begin
      rfsh_stb <= 1'b0;
      unique case (mode_q)
        RM_IDLE: begin
          if (start_kind == CK_INT) begin
            rfsh_stb <= 1'b1;
            rfsh_row <= cnt_q;
            mode_q   <= RM_INT;
          end else if (start_kind == CK_SELF) begin
            tmr_q  <= '0;
            mode_q <= RM_SELF;
          end
        end
        RM_INT: begin
          // counter moves on only when the refresh cycle closes
          if (stop) begin
            cnt_q  <= cnt_q + 1'b1;
            mode_q <= RM_IDLE;
          end
        end
        RM_SELF: begin
          if (stop) begin
            rec_q  <= '0;
            mode_q <= RM_RECOV;
          end else if (tmr_q == TMR_LAST) begin
            rfsh_stb <= 1'b1;
            rfsh_row <= cnt_q;
            cnt_q    <= cnt_q + 1'b1;
            tmr_q    <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        RM_RECOV: begin
          if (rec_q == REC_LAST) mode_q <= RM_IDLE;
          else                   rec_q  <= rec_q + 1'b1;
        end
        default: mode_q <= RM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfsq_init.sv
module rfsq_init
  import rfsq_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int INIT_CYC = 8,
  parameter int BANK_HI  = 9,
  parameter int BANK_LO  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  cyc_kind_t        start_kind,
  input  logic [ROW_W-1:0] row_addr,
  output logic             ready
);
  localparam int NUM_BANKS = 4;
  localparam int ACT_W     = $clog2(INIT_CYC + 1);
  localparam logic [ACT_W-1:0] ACT_FULL = ACT_W'(INIT_CYC);

  logic [ACT_W-1:0]     act_q;
  logic                 act_done;
  logic                 counted;
  logic                 rd_ok;
  logic [1:0]           bank_idx;
  logic [NUM_BANKS-1:0] done_vec;

  assign act_done = (act_q == ACT_FULL);
  assign counted  = (start_kind == CK_INT) || (start_kind == CK_RD) || (start_kind == CK_WR);
  assign rd_ok    = (start_kind == CK_RD) && act_done;
  assign bank_idx = {row_addr[BANK_HI], row_addr[BANK_LO]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_st_t         st_q;
    logic [ROW_W-1:0] first_q;
    assign done_vec[b] = (st_q == BK_DONE);
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q    <= BK_EMPTY;
        first_q <= '0;
      end else if (rd_ok && (bank_idx == 2'(b))) begin
        if (st_q == BK_EMPTY) begin
          st_q    <= BK_ONE;
          first_q <= row_addr;
        end else if ((st_q == BK_ONE) && (row_addr != first_q)) begin
          st_q <= BK_DONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      ready <= 1'b0;
    end else begin
      if (counted && !act_done) act_q <= act_q + 1'b1;
      ready <= ready | (act_done & (&done_vec));
    end
  end
endmodule

// File: rtl/rfsq_ddl.sv
module rfsq_ddl #(
  parameter int WIN_CYC  = 256,
  parameter int MIN_RFSH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic ext,
  output logic dl_err
);
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam int RC_W  = $clog2(MIN_RFSH + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [RC_W:0]    MIN_EXT  = (RC_W+1)'(MIN_RFSH);

  logic [WIN_W-1:0] win_q;
  logic [RC_W-1:0]  rc_q;
  logic [1:0]       ev;
  logic [RC_W:0]    sum;

  assign ev  = {1'b0, stb} + {1'b0, ext};
  assign sum = (RC_W+1)'(rc_q) + (RC_W+1)'(ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      rc_q   <= '0;
      dl_err <= 1'b0;
    end else if (win_q == WIN_LAST) begin
      dl_err <= (sum < MIN_EXT);
      rc_q   <= '0;
      win_q  <= '0;
    end else begin
      rc_q  <= (sum > MIN_EXT) ? RC_W'(MIN_RFSH) : sum[RC_W-1:0];
      win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsq_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int RFSH_ROW_W = 10,
  parameter int SR_PERIOD  = 16,
  parameter int PRECHG_CYC = 4,
  parameter int INIT_CYC   = 8,
  parameter int BANK_HI    = 9,
  parameter int BANK_LO    = 2,
  parameter int WIN_CYC    = 256,
  parameter int MIN_RFSH   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  row_act,
  input  logic                  sel,
  input  logic                  wr_mode,
  input  logic                  rfsh_req,
  input  logic                  col_strobe,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      row_addr,
  output logic                  rfsh_stb,
  output logic [RFSH_ROW_W-1:0] rfsh_row,
  output logic                  self_rfsh,
  output logic                  ready,
  output logic                  dl_err
);
  cyc_kind_t start_kind;
  logic      stop;
  logic      ext_rfsh;
  logic      blk;

  rfsq_cycdec u_dec (
    .clk        (clk),
    .rst        (rst),
    .row_act    (row_act),
    .sel        (sel),
    .wr_mode    (wr_mode),
    .rfsh_req   (rfsh_req),
    .col_strobe (col_strobe),
    .wr_en      (wr_en),
    .blk        (blk),
    .start_kind (start_kind),
    .stop       (stop),
    .ext_rfsh   (ext_rfsh)
  );

  rfsq_rowctr #(
    .RFSH_ROW_W (RFSH_ROW_W),
    .SR_PERIOD  (SR_PERIOD),
    .PRECHG_CYC (PRECHG_CYC)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .start_kind (start_kind),
    .stop       (stop),
    .rfsh_stb   (rfsh_stb),
    .rfsh_row   (rfsh_row),
    .self_rfsh  (self_rfsh),
    .blk        (blk)
  );

  rfsq_init #(
    .ROW_W    (ROW_W),
    .INIT_CYC (INIT_CYC),
    .BANK_HI  (BANK_HI),
    .BANK_LO  (BANK_LO)
  ) u_init (
    .clk        (clk),
    .rst        (rst),
    .start_kind (start_kind),
    .row_addr   (row_addr),
    .ready      (ready)
  );

  rfsq_ddl #(
    .WIN_CYC  (WIN_CYC),
    .MIN_RFSH (MIN_RFSH)
  ) u_ddl (
    .clk    (clk),
    .rst    (rst),
    .stb    (rfsh_stb),
    .ext    (ext_rfsh),
    .dl_err (dl_err)
  );
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int RFSH_ROW_W = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  row_act,
  input logic                  sel,
  input logic                  col_strobe,
  input logic                  rfsh_stb,
  input logic [RFSH_ROW_W-1:0] rfsh_row,
  input logic                  self_rfsh,
  input logic                  ready,
  input logic                  dl_err
);
  logic                  seen_q;
  logic [RFSH_ROW_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (rfsh_stb) begin
      seen_q <= 1'b1;
      last_q <= rfsh_row;
    end
  end

  assert_stb_single_R1: assert property (@(posedge clk) disable iff (rst)
    rfsh_stb |=> !rfsh_stb);

  assert_row_step_R2: assert property (@(posedge clk) disable iff (rst)
    (rfsh_stb && seen_q) |-> (rfsh_row == RFSH_ROW_W'(last_q + 1'b1)));

  assert_self_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(self_rfsh) |-> ($past(row_act) && !$past(sel) && $past(col_strobe)));

  assert_self_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (self_rfsh && row_act) |=> self_rfsh);

  assert_exit_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(self_rfsh) |=> !rfsh_stb);

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!rfsh_stb && !self_rfsh && !ready && !dl_err));
endmodule

bind rfsh_seq rfsh_seq_chk #(.RFSH_ROW_W(RFSH_ROW_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .row_act    (row_act),
  .sel        (sel),
  .col_strobe (col_strobe),
  .rfsh_stb   (rfsh_stb),
  .rfsh_row   (rfsh_row),
  .self_rfsh  (self_rfsh),
  .ready      (ready),
  .dl_err     (dl_err)
);

// File: tb/test_rfsh_seq.sv
`timescale 1ns/1ps
module test_rfsh_seq;
  localparam int ROW_W = 11;
  localparam int RW    = 10;
  localparam int NROWS = 1024;
  localparam int SRP   = 16;
  localparam int PRE   = 4;
  localparam int INIT  = 8;
  localparam int WIN   = 256;
  localparam int MINR  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_act = 1'b0, sel = 1'b0, wr_mode = 1'b0, rfsh_req = 1'b0;
  logic col_strobe = 1'b0, wr_en = 1'b0;
  logic [ROW_W-1:0] row_addr = '0;
  logic rfsh_stb, self_rfsh, ready, dl_err;
  logic [RW-1:0] rfsh_row;

  int total = 0;
  int bad   = 0;
  int nstb  = 0;
  int lastrow = -1;

  always #4 clk = ~clk;

  rfsh_seq #(
    .ROW_W(ROW_W), .RFSH_ROW_W(RW), .SR_PERIOD(SRP), .PRECHG_CYC(PRE),
    .INIT_CYC(INIT), .BANK_HI(9), .BANK_LO(2), .WIN_CYC(WIN), .MIN_RFSH(MINR)
  ) i_rfsh_seq (
    .clk(clk), .rst(rst), .row_act(row_act), .sel(sel), .wr_mode(wr_mode),
    .rfsh_req(rfsh_req), .col_strobe(col_strobe), .wr_en(wr_en),
    .row_addr(row_addr), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row),
    .self_rfsh(self_rfsh), .ready(ready), .dl_err(dl_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, evaluated at every rising edge
  int m_pra, m_ck, m_cs, m_mode, m_cnt, m_tmr, m_rec, m_act, m_win, m_rc;
  int m_bst [4];
  int m_first [4];
  int e_stb, e_row, e_rdy, e_dl;

  always @(posedge clk) begin
    if (rst) begin
      m_pra = 0; m_ck = 0; m_cs = 0; m_mode = 0; m_cnt = 0; m_tmr = 0;
      m_rec = 0; m_act = 0; m_win = 0; m_rc = 0;
      e_stb = 0; e_row = 0; e_rdy = 0; e_dl = 0;
      for (int b = 0; b < 4; b++) begin m_bst[b] = 0; m_first[b] = 0; end
    end else begin
      int ra, st, sp, kind, ext, ev, stb_n, all_done, bk;
      ra = int'(row_act);
      st = (ra == 1 && m_pra == 0) ? 1 : 0;
      sp = (ra == 0 && m_pra == 1) ? 1 : 0;
      kind = 0;
      if (st == 1 && m_mode != 3) begin
        if (rfsh_req) kind = 1;
        else if (!sel && wr_mode && !wr_en && col_strobe) kind = 2;
        else if (!sel) kind = 0;
        else if (wr_mode) kind = 4;
        else kind = 3;
      end
      ext = (sp == 1 && m_ck == 4 && m_cs == 0) ? 1 : 0;
      if (st == 1) begin m_ck = kind; m_cs = int'(col_strobe); end
      else if (col_strobe) m_cs = 1;
      // deadline window
      ev = e_stb + ext;
      if (m_win == WIN - 1) begin
        e_dl = (m_rc + ev < MINR) ? 1 : 0; m_rc = 0; m_win = 0;
      end else begin
        m_rc = (m_rc + ev > MINR) ? MINR : m_rc + ev; m_win++;
      end
      // start-up tracking
      all_done = 1;
      for (int b = 0; b < 4; b++) if (m_bst[b] != 2) all_done = 0;
      if (m_act == INIT && all_done == 1) e_rdy = 1;
      if (kind == 3 && m_act == INIT) begin
        bk = {row_addr[9], row_addr[2]};
        if (m_bst[bk] == 0) begin m_bst[bk] = 1; m_first[bk] = int'(row_addr); end
        else if (m_bst[bk] == 1 && int'(row_addr) != m_first[bk]) m_bst[bk] = 2;
      end
      if ((kind == 1 || kind == 3 || kind == 4) && m_act < INIT) m_act++;
      // refresh counter and modes
      stb_n = 0;
      case (m_mode)
        0: if (kind == 1) begin stb_n = 1; e_row = m_cnt; m_mode = 1; end
           else if (kind == 2) begin m_tmr = 0; m_mode = 2; end
        1: if (sp == 1) begin m_cnt = (m_cnt + 1) % NROWS; m_mode = 0; end
        2: if (sp == 1) begin m_rec = 0; m_mode = 3; end
           else if (m_tmr == SRP - 1) begin
             stb_n = 1; e_row = m_cnt; m_cnt = (m_cnt + 1) % NROWS; m_tmr = 0;
           end else m_tmr++;
        default: if (m_rec == PRE - 1) m_mode = 0; else m_rec++;
      endcase
      e_stb = stb_n;
      m_pra = ra;
    end
  end

  // compare every cycle and count strobes
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 strobe vs model", int'(rfsh_stb), e_stb);
      chk("R2 row vs model", int'(rfsh_row), e_row);
      chk("R4 self flag vs model", int'(self_rfsh), (m_mode == 2) ? 1 : 0);
      chk("R6 ready vs model", int'(ready), e_rdy);
      chk("R9 deadline vs model", int'(dl_err), e_dl);
      if (rfsh_stb) begin nstb++; lastrow = int'(rfsh_row); end
    end
  end

  task automatic op(input logic f_sel, input logic f_wr, input logic f_rf,
                    input logic f_col, input logic f_we, input int row, input int len);
    sel = f_sel; wr_mode = f_wr; rfsh_req = f_rf; col_strobe = f_col; wr_en = f_we;
    row_addr = ROW_W'(row); row_act = 1'b1;
    repeat (len) @(negedge clk);
    row_act = 1'b0; sel = 1'b0; wr_mode = 1'b0; rfsh_req = 1'b0;
    col_strobe = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R10 strobe in reset", int'(rfsh_stb), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 row after reset", int'(rfsh_row), 0);
    chk("R10 self after reset", int'(self_rfsh), 0);
    chk("R10 ready after reset", int'(ready), 0);
    chk("R10 dl_err after reset", int'(dl_err), 0);

    // R3: deselected reads do nothing
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 'h004, 2);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 'h200, 2);
    chk("R3 deselected no strobe", nstb, 0);

    // R1 R2: three internal refreshes, first one deselected
    op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 2);
    chk("R1 strobe with deselect", nstb, 1);
    chk("R1 first row", lastrow, 0);
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1);
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 3);
    chk("R2 three strobes", nstb, 3);
    chk("R2 third row", lastrow, 2);

    // early read (ignored for banks), then writes to reach eight
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h003, 1);
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 'h010, 2);
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 'h011, 2);
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 'h012, 2);
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 'h013, 2);
    chk("R8 writes give no strobe", nstb, 3);

    // R6 R7: bank reads
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h004, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h005, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h200, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h201, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h204, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h205, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h000, 1);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h000, 1);
    repeat (4) @(negedge clk);
    chk("R7 same row keeps not ready", int'(ready), 0);
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h001, 1);
    repeat (3) @(negedge clk);
    chk("R6 ready after bank reads", int'(ready), 1);

    // R4: self-refresh for 52 edges
    base = nstb;
    sel = 1'b0; wr_mode = 1'b1; rfsh_req = 1'b0; wr_en = 1'b0; col_strobe = 1'b1;
    row_act = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4 self flag high", int'(self_rfsh), 1);
    repeat (42) @(negedge clk);
    row_act = 1'b0; wr_mode = 1'b0; col_strobe = 1'b0;
    @(negedge clk);
    chk("R4 self strobes", nstb - base, 3);
    chk("R4 self last row", lastrow, 5);
    chk("R4 self flag low after exit", int'(self_rfsh), 0);

    // R5: refresh request in recovery gap is dropped
    base = nstb;
    sel = 1'b1; rfsh_req = 1'b1; row_act = 1'b1;
    repeat (2) @(negedge clk);
    row_act = 1'b0; rfsh_req = 1'b0; sel = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 blocked in recovery", nstb - base, 0);
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1);
    chk("R5 refresh after recovery", nstb - base, 1);
    chk("R2 row after self", lastrow, 6);

    // R2: wrap of the counter
    for (int i = 0; i < 1017; i++) op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1);
    chk("R2 top row", lastrow, NROWS - 1);
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1);
    chk("R2 wrap to zero", lastrow, 0);

    // R9 R8: deadline monitor
    repeat (600) @(negedge clk);
    chk("R9 idle window flagged", int'(dl_err), 1);
    for (int i = 0; i < 200; i++) op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 'h020, 1);
    chk("R8 reads are not refreshes", int'(dl_err), 1);
    for (int i = 0; i < 200; i++) op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 'h021, 1);
    chk("R8 column-less writes refresh", int'(dl_err), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule